// File: doc/BRIEF.md
# Consecutive Limit Alert Filter

This block debounces limit violations for a multi-channel temperature monitor. Each measurement arrives with a channel index, a signed temperature and a diode-fault flag. The block compares it against that channel's limits and keeps a per-channel counter of back-to-back violations. A channel raises the alert only after the violation has repeated a programmed number of times on that channel's own readings. Readings of other channels between them do not break the run.

The filter has two modes, selected by an input pin. In latched (interrupt) mode, high-limit, low-limit and diode-fault readings all count. When the count is reached, the channel's sticky status bit and the error-type bits of that reading are set, and the counter restarts from zero. In comparator mode, only readings above the high limit count. The counter then saturates, and the alert stays up until a reading falls below the high limit minus a hysteresis amount.

A second counter per channel drives a shutdown request. It counts readings above the channel's therm limit; on the external channel, readings above a separate hardware shutdown limit also count. An 8-bit control register holds both required counts and the bus-timeout enable.

Top module: `cons_alert_filter`

## Requirements
- R1: The control register resets to 0x70 and is loaded from `cfg_wdata` by `cfg_we`. It reads back unchanged on `cfg_q`. Bit 7 drives `bus_tmo_en`. Bits 6:4 give the shutdown count and bits 3:1 give the alert count, each decoded as field + 1 (1..8). Bit 0 has no function.
- R2: In latched mode (`cmp_mode`=0), a channel's counter advances on a reading with temp > high limit, temp < low limit, or fault set. Any reading without such a condition clears the counter to 0.
- R3: In latched mode, when a reading brings the counter to the alert count, the channel's `ch_status` bit is set. The counter returns to 0. Among `err_hi`/`err_lo`/`err_flt`, the bits matching that reading's conditions are set.
- R4: `alert` is high while any unmasked channel (`mask` bit 0) has its status bit set or is in comparator hold. A masked channel still sets its status bit but never raises `alert`.
- R5: Status and error bits stay set until `stat_clr`. When `stat_clr` coincides with a new firing of a channel, that channel's new bits survive and the others clear.
- R6: In comparator mode only temp > high limit advances the counter. Fault and low readings are treated as in-limit. On reaching the alert count the counter saturates at that count and the channel enters hold.
- R7: A held channel releases hold and clears its counter only on a reading with temp < high limit − `hyst`. Readings at or above that level keep both the hold and the counter.
- R8: Counters change only on readings of their own channel. Other channels' readings leave them unchanged.
- R9: A channel's shutdown counter advances on temp > its therm limit. For the external channel (index 1) it also advances on temp > `shdn_lim`. It saturates at the shutdown count and clears on any other reading of that channel. `shdn` is high while any channel's counter is at the shutdown count.
- R10: A measurement is taken on the clock edge where `meas_valid` is high. All outputs show its effect right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register contents |
| bus_tmo_en | output | 1 | Bus timeout enable (bit 7) |
| cmp_mode | input | 1 | 1 = comparator mode, 0 = latched mode |
| meas_valid | input | 1 | Measurement present this cycle |
| meas_ch | input | 1 | Channel index (0 internal, 1 external) |
| meas_temp | input | 10 | Signed temperature |
| meas_fault | input | 1 | Diode fault on this reading |
| hi_lim | input | 20 | Per-channel signed high limits, channel c at [c*10 +: 10] |
| lo_lim | input | 20 | Per-channel signed low limits |
| therm_lim | input | 20 | Per-channel signed therm limits |
| shdn_lim | input | 10 | Signed hardware shutdown limit, external channel |
| hyst | input | 10 | Unsigned hysteresis |
| mask | input | 2 | Per-channel alert mask |
| stat_clr | input | 1 | Clear status and error bits |
| alert_cnt | output | 8 | Alert counters, channel c at [c*4 +: 4] |
| ch_status | output | 2 | Sticky per-channel status |
| err_hi | output | 2 | Sticky high-limit error bits |
| err_lo | output | 2 | Sticky low-limit error bits |
| err_flt | output | 2 | Sticky fault error bits |
| alert | output | 1 | Alert output |
| shdn | output | 1 | Shutdown request |

## Verification
The hardest situation to reach is interleaving between channels. One channel's run must survive the other channel's readings, and one channel must fire while the other holds a partial count. The bench replays a five-step, two-channel sequence with a count of four and checks both counters after every reading. The alert must appear only on the external channel's fifth reading. A second hard case is a status clear landing on the same edge as a new firing. The bench times a reading and the clear strobe into one cycle and checks that only the new bit survives.

// File: rtl/caf_pkg.sv
package caf_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic       tmo_en;
    logic [2:0] therm_n;
    logic [2:0] alert_n;
    logic       spare;
  } caf_cfg_t;

  localparam logic [7:0] CFG_RST = 8'h70;

  // Required repeat count for a 3-bit field: field + 1.
  function automatic logic [CNT_W-1:0] need_of(input logic [2:0] f);
    return CNT_W'({1'b0, f}) + CNT_W'(1);
  endfunction

  // Increment that stops at lim.
  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] lim);
    return (c + 1'b1 >= lim) ? lim : c + 1'b1;
  endfunction
endpackage

// File: rtl/caf_cfg.sv
module caf_cfg
  import caf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output caf_cfg_t   cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= caf_cfg_t'(CFG_RST);
    else if (we) cfg <= caf_cfg_t'(wdata);
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg == caf_cfg_t'($past(wdata))));
endmodule

// File: rtl/caf_chan.sv
module caf_chan
  import caf_pkg::*;
#(
  parameter int TW     = 10,
  parameter bit IS_EXT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  logic                 cmp_mode,
  input  logic signed [TW-1:0] temp,
  input  logic                 fault,
  input  logic signed [TW-1:0] hi_lim,
  input  logic signed [TW-1:0] lo_lim,
  input  logic signed [TW-1:0] therm_lim,
  input  logic signed [TW-1:0] shdn_lim,
  input  logic        [TW-1:0] hyst,
  input  logic [CNT_W-1:0]     need_a,
  input  logic [CNT_W-1:0]     need_t,
  input  logic                 stat_clr,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 status_o,
  output logic                 e_hi_o,
  output logic                 e_lo_o,
  output logic                 e_flt_o,
  output logic                 hold_o,
  output logic                 shdn_req_o
);
  // Release level: high limit minus hysteresis, one bit wider.
  function automatic logic signed [TW:0] rel_level(input logic signed [TW-1:0] h,
                                                   input logic [TW-1:0] y);
    return $signed({h[TW-1], h}) - $signed({1'b0, y});
  endfunction

  logic [CNT_W-1:0] cnt, tcnt, cnt_inc;
  logic status, e_hi, e_lo, e_flt, hold;

  // Named events for the assertions.
  logic is_hi, is_lo, int_bad, below_rel, therm_over;
  logic fire_int, fire_cmp, release_cmp;

  assign is_hi      = temp > hi_lim;
  assign is_lo      = temp < lo_lim;
  assign int_bad    = is_hi | is_lo | fault;
  assign below_rel  = $signed({temp[TW-1], temp}) < rel_level(hi_lim, hyst);
  assign therm_over = (temp > therm_lim) || (IS_EXT && (temp > shdn_lim));
  assign cnt_inc    = cnt + 1'b1;

  assign fire_int    = hit && !cmp_mode && int_bad && (cnt_inc >= need_a);
  assign fire_cmp    = hit && cmp_mode && !hold && is_hi && (cnt_inc >= need_a);
  assign release_cmp = hit && cmp_mode && hold && below_rel;

  // Alert counter and comparator hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= 1'b0;
    end else begin
      if (!cmp_mode) hold <= 1'b0;
      if (hit) begin
        if (cmp_mode) begin
          if (hold) begin
            if (release_cmp) begin
              hold <= 1'b0;
              cnt  <= '0;
            end
          end else if (is_hi) begin
            cnt <= sat_step(cnt, need_a);
            if (fire_cmp) hold <= 1'b1;
          end else begin
            cnt <= '0;
          end
        end else begin
          cnt <= (!int_bad || fire_int) ? '0 : cnt_inc;
        end
      end
    end
  end

  // Sticky status and error-type bits; a new firing wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      e_hi   <= 1'b0;
      e_lo   <= 1'b0;
      e_flt  <= 1'b0;
    end else if (fire_int) begin
      status <= 1'b1;
      e_hi   <= (e_hi  & ~stat_clr) | is_hi;
      e_lo   <= (e_lo  & ~stat_clr) | is_lo;
      e_flt  <= (e_flt & ~stat_clr) | fault;
    end else if (stat_clr) begin
      status <= 1'b0;
      e_hi   <= 1'b0;
      e_lo   <= 1'b0;
      e_flt  <= 1'b0;
    end
  end

  // Shutdown counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tcnt <= '0;
    else if (hit) tcnt <= therm_over ? sat_step(tcnt, need_t) : '0;
  end

  assign cnt_o      = cnt;
  assign status_o   = status;
  assign e_hi_o     = e_hi;
  assign e_lo_o     = e_lo;
  assign e_flt_o    = e_flt;
  assign hold_o     = hold;
  assign shdn_req_o = (tcnt >= need_t);

  assert_clean_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmp_mode && !is_hi && !is_lo && !fault) |=> (cnt == '0));
  assert_fire_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_int |=> (status && cnt == '0));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !stat_clr) |=> status);
  assert_hold_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp_mode && hold && !below_rel) |=> (hold && $stable(cnt)));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_cmp |=> (!hold && cnt == '0));
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(cnt) && $stable(tcnt)));
endmodule

// File: rtl/cons_alert_filter.sv
module cons_alert_filter
  import caf_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int TW     = 10,
  parameter int EXT_CH = 1,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_q,
  output logic                 bus_tmo_en,
  input  logic                 cmp_mode,
  input  logic                 meas_valid,
  input  logic [CHW-1:0]       meas_ch,
  input  logic [TW-1:0]        meas_temp,
  input  logic                 meas_fault,
  input  logic [NCH*TW-1:0]    hi_lim,
  input  logic [NCH*TW-1:0]    lo_lim,
  input  logic [NCH*TW-1:0]    therm_lim,
  input  logic [TW-1:0]        shdn_lim,
  input  logic [TW-1:0]        hyst,
  input  logic [NCH-1:0]       mask,
  input  logic                 stat_clr,
  output logic [NCH*CNT_W-1:0] alert_cnt,
  output logic [NCH-1:0]       ch_status,
  output logic [NCH-1:0]       err_hi,
  output logic [NCH-1:0]       err_lo,
  output logic [NCH-1:0]       err_flt,
  output logic                 alert,
  output logic                 shdn
);
  caf_cfg_t         cfg;
  logic [CNT_W-1:0] need_a, need_t;
  logic [NCH-1:0]   hold_v, shdn_v;

  caf_cfg u_cfg (.clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg));

  assign cfg_q      = cfg;
  assign bus_tmo_en = cfg.tmo_en;
  assign need_a     = need_of(cfg.alert_n);
  assign need_t     = need_of(cfg.therm_n);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    caf_chan #(.TW(TW), .IS_EXT(c == EXT_CH)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (meas_valid && (meas_ch == CHW'(c))),
      .cmp_mode  (cmp_mode),
      .temp      (meas_temp),
      .fault     (meas_fault),
      .hi_lim    (hi_lim[c*TW +: TW]),
      .lo_lim    (lo_lim[c*TW +: TW]),
      .therm_lim (therm_lim[c*TW +: TW]),
      .shdn_lim  (shdn_lim),
      .hyst      (hyst),
      .need_a    (need_a),
      .need_t    (need_t),
      .stat_clr  (stat_clr),
      .cnt_o     (alert_cnt[c*CNT_W +: CNT_W]),
      .status_o  (ch_status[c]),
      .e_hi_o    (err_hi[c]),
      .e_lo_o    (err_lo[c]),
      .e_flt_o   (err_flt[c]),
      .hold_o    (hold_v[c]),
      .shdn_req_o(shdn_v[c])
    );
  end

  assign alert = |((ch_status | hold_v) & ~mask);
  assign shdn  = |shdn_v;

  assert_all_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !alert);
endmodule

// File: tb/cons_alert_filter_tb_top.sv
module cons_alert_filter_tb_top;
  localparam int TW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       cfg_we = 0, cmp_mode = 0, meas_valid = 0, meas_ch = 0, meas_fault = 0, stat_clr = 0;
  logic [7:0] cfg_wdata = 0, cfg_q;
  logic       bus_tmo_en, alert, shdn;
  logic [TW-1:0]   meas_temp = 0, shdn_lim = 10'sd100, hyst = 10'd5;
  logic [2*TW-1:0] hi_lim, lo_lim, therm_lim;
  logic [1:0] mask = 0, ch_status, err_hi, err_lo, err_flt;
  logic [7:0] alert_cnt;

  int total = 0, bad = 0;
  bit done = 0;

  cons_alert_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .bus_tmo_en(bus_tmo_en), .cmp_mode(cmp_mode), .meas_valid(meas_valid),
    .meas_ch(meas_ch), .meas_temp(meas_temp), .meas_fault(meas_fault),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .therm_lim(therm_lim), .shdn_lim(shdn_lim),
    .hyst(hyst), .mask(mask), .stat_clr(stat_clr), .alert_cnt(alert_cnt),
    .ch_status(ch_status), .err_hi(err_hi), .err_lo(err_lo), .err_flt(err_flt),
    .alert(alert), .shdn(shdn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt_of(input int c);
    return int'(alert_cnt[c*4 +: 4]);
  endfunction

  // One reading; outputs are checked on the following falling edge.
  task automatic meas(input logic ch, input int t, input logic f, input logic clr = 1'b0);
    @(negedge clk);
    meas_valid = 1; meas_ch = ch; meas_temp = TW'(t); meas_fault = f; stat_clr = clr;
    @(negedge clk);
    meas_valid = 0; meas_fault = 0; stat_clr = 0;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic settle();
    meas(0, 25, 0); meas(1, 25, 0);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "cfg after reset", cfg_q, 8'h70);
    chk("R1", "timeout enable after reset", bus_tmo_en, 0);
    chk("R10", "alert after reset", alert, 0);
    chk("R9", "shdn after reset", shdn, 0);
    chk("R2", "counters after reset", alert_cnt, 0);
    wr_cfg(8'hF1);
    chk("R1", "cfg readback", cfg_q, 8'hF1);
    chk("R1", "timeout enable bit 7", bus_tmo_en, 1);
  endtask

  // Five steps, count 4 (field 3), high limit 70 on both channels
  task automatic t_sequence();
    int t0[5] = '{71, 71, 69, 71, 71};
    int t1[5] = '{69, 71, 71, 71, 71};
    int e0[5] = '{1, 2, 0, 1, 2};
    int e1[5] = '{0, 1, 2, 3, 0};
    wr_cfg(8'h76);
    settle();
    for (int s = 0; s < 5; s++) begin
      meas(0, t0[s], 0);
      chk("R8", "seq internal count", cnt_of(0), e0[s]);
      chk("R4", "seq alert after internal reading", alert, 0);
      meas(1, t1[s], 0);
      chk("R2", "seq external count", cnt_of(1), e1[s]);
      chk("R8", "seq internal count held", cnt_of(0), e0[s]);
      chk("R3", "seq alert after external reading", alert, (s == 4) ? 1 : 0);
    end
    chk("R3", "seq status only external", ch_status, 2'b10);
    chk("R3", "seq high error bit", err_hi, 2'b10);
    chk("R3", "seq low/fault bits", {err_lo, err_flt}, 0);
    @(negedge clk);
    chk("R5", "status sticky without clear", ch_status, 2'b10);
  endtask

  task automatic t_low_fault();
    wr_cfg(8'h72);
    settle();
    meas(0, -50, 0);
    chk("R2", "low reading counts", cnt_of(0), 1);
    meas(0, 25, 1);
    chk("R3", "fault completes count", ch_status, 2'b01);
    chk("R3", "fault error bit", err_flt, 2'b01);
    chk("R3", "low bit not set by fault reading", err_lo, 0);
    chk("R3", "counter cleared after fire", cnt_of(0), 0);
    chk("R4", "alert from fault", alert, 1);
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
    chk("R5", "clear drops status", ch_status, 0);
    chk("R5", "clear drops alert", alert, 0);
    meas(0, 80, 0);
    meas(0, 25, 0);
    chk("R2", "clean reading clears count", cnt_of(0), 0);
  endtask

  task automatic t_mask();
    wr_cfg(8'h70);
    settle();
    mask = 2'b01;
    meas(0, 75, 0);
    chk("R4", "masked channel status", ch_status, 2'b01);
    chk("R4", "masked channel no alert", alert, 0);
    mask = 2'b00;
    @(negedge clk);
    chk("R4", "unmasked channel alert", alert, 1);
  endtask

  task automatic t_clear_race();
    wr_cfg(8'h70);
    settle();
    meas(1, 75, 0);
    chk("R3", "external fires at count 1", ch_status, 2'b10);
    meas(0, -60, 0, 1);
    chk("R5", "firing wins over same-cycle clear", ch_status, 2'b01);
    chk("R5", "old high bit cleared", err_hi, 0);
    chk("R5", "new low bit kept", err_lo, 2'b01);
  endtask

  task automatic t_compare();
    wr_cfg(8'h72);
    settle();
    cmp_mode = 1;
    meas(0, 71, 0);
    chk("R6", "cmp high counts", cnt_of(0), 1);
    meas(0, 25, 1);
    chk("R6", "cmp fault ignored", cnt_of(0), 0);
    meas(0, -50, 0);
    chk("R6", "cmp low ignored", cnt_of(0), 0);
    meas(0, 71, 0);
    meas(0, 72, 0);
    chk("R6", "cmp reaches count", cnt_of(0), 2);
    chk("R6", "cmp alert", alert, 1);
    chk("R6", "cmp no status", ch_status, 0);
    meas(0, 80, 0);
    chk("R6", "cmp saturates", cnt_of(0), 2);
    meas(0, 66, 0);
    chk("R7", "cmp hold in band", alert, 1);
    meas(0, 65, 0);
    chk("R7", "cmp hold at release level", alert, 1);
    chk("R7", "cmp count kept at level", cnt_of(0), 2);
    meas(0, 64, 0);
    chk("R7", "cmp release", alert, 0);
    chk("R7", "cmp count cleared", cnt_of(0), 0);
    cmp_mode = 0;
  endtask

  task automatic t_therm();
    wr_cfg(8'h1E);
    hi_lim = {10'sd200, 10'sd200};
    settle();
    meas(1, 101, 0);
    chk("R9", "ext one over shutdown limit", shdn, 0);
    meas(1, 101, 0);
    chk("R9", "ext shutdown", shdn, 1);
    meas(1, 90, 0);
    chk("R9", "ext cleared", shdn, 0);
    meas(0, 110, 0); meas(0, 110, 0);
    chk("R9", "int ignores shutdown limit", shdn, 0);
    therm_lim = {10'sd120, 10'sd85};
    meas(0, 90, 0); meas(0, 90, 0);
    chk("R9", "int over therm limit", shdn, 1);
    meas(1, 25, 0);
    chk("R9", "other channel leaves shdn", shdn, 1);
    meas(0, 80, 0);
    chk("R9", "int cleared", shdn, 0);
  endtask

  initial begin
    hi_lim = {10'sd70, 10'sd70};
    lo_lim = {-10'sd40, -10'sd40};
    therm_lim = {10'sd120, 10'sd120};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sequence();
    t_low_fault();
    t_mask();
    t_clear_race();
    t_compare();
    t_therm();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule